// File: doc/BRIEF.md
# GPIO Bank Interrupt Cause Unit

This block is a bank of general-purpose I/O lines, 32 of them by default, with per-line direction, output level, input polarity and interrupt gating. Software reaches it through a plain register port: a 3-bit register select, a write strobe and one data word, with read data returned combinationally for the selected register. Output lines are driven from an output register whenever their direction bit selects output.

Every pin passes through a two-flop synchronizer. The synchronized level is XORed with the line's polarity bit to form the data-in value, and both interrupt paths use that value. The level path ANDs data-in with a level mask and does not latch. The edge path watches data-in for a 0-to-1 change and records it in a sticky edge-cause register. Software clears a recorded edge by writing 0 to its bit. A falling pin edge is caught by setting the polarity bit. The edge causes are ANDed with an edge mask and ORed with the level causes. The per-line results are then ORed within each group of eight consecutive lines, which gives four summary interrupt outputs.

The register select codes are DIR=0, OUT=1, POL=2, DIN=3 (read-only), ECAUSE=4, EMASK=5, LMASK=6. Code 7 reads as zero. In every register, bit n belongs to line n.

Top module: `gpio_cause_bank`

## Requirements
- R1: After reset, DIR (code 0) reads all ones, pin_oe is all zeros, OUT, POL, ECAUSE, EMASK and LMASK read zero, and irq_group is zero.
- R2: DIN (code 3) reads pin_in XOR POL. A pin change appears in DIN two clock edges after it is applied, and not after one.
- R3: A DIR bit of 0 drives pin_oe high for that line. pin_out always carries the OUT register (code 1).
- R4: The level cause of line n is DIN[n] AND LMASK[n] (code 6). It is not latched, so it drops as soon as the data-in bit drops.
- R5: A 0-to-1 change of DIN[n] sets ECAUSE[n] (code 4) one edge later, and the bit stays set after the pin returns.
- R6: With POL[n]=1, a falling pin edge sets ECAUSE[n]. A pin with POL[n]=0 that falls leaves ECAUSE[n] at 0.
- R7: A write to ECAUSE clears each bit written as 0 and keeps each bit written as 1. So writing all ones except bit n clears only bit n.
- R8: The edge cause of line n is ECAUSE[n] AND EMASK[n] (code 5). A recorded edge with its mask bit at 0 raises no interrupt.
- R9: irq_group[g] is the OR of the level and edge causes of lines 8g to 8g+7. A cause on one line raises only its own group's output.
- R10: If a new edge on line n and a clearing write of ECAUSE[n] fall in the same cycle, ECAUSE[n] stays set.
- R11: A write to DIN (code 3) changes no register, and DIN still reads pin_in XOR POL afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select code |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels from OUT |
| pin_oe | output | 32 | Per-line output enable, the inverse of DIR |
| irq_group | output | 4 | One summary interrupt per eight-line group |

## Verification
The bench checks when data-in changes, one edge after the pin and then two edges after it. A design with one synchronizer stage too few or too many shows the new value at the wrong edge. It drives an edge into the same cycle as a clearing write. A design where the clear wins loses that interrupt. It clears one edge bit by writing all ones except that bit. A design with inverted write-to-clear sense wipes the wrong bits or keeps the target bit. It also uses lines at group boundaries (7, 8, 31) and drops a level source. A design that latches level causes keeps irq_group raised after the pin falls, and one with a wrong group slice raises the wrong output.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
    typedef enum logic [2:0] {
        REG_DIR    = 3'd0,
        REG_OUT    = 3'd1,
        REG_POL    = 3'd2,
        REG_DIN    = 3'd3,
        REG_ECAUSE = 3'd4,
        REG_EMASK  = 3'd5,
        REG_LMASK  = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpiob_edge_cause.sv
module gpiob_edge_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] din_prev,
    output logic [W-1:0] cause
);
    logic [W-1:0] rise;
    logic [W-1:0] keep;

    // A 0-to-1 change of data-in is an event. An event in the same cycle wins over a clear.
    assign rise = din & ~din_prev;
    assign keep = clr_we ? clr_data : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_prev <= '0;
            cause    <= '0;
        end else begin
            din_prev <= din;
            cause    <= (cause & keep) | rise;
        end
    end
endmodule

// File: rtl/gpiob_group_or.sv
module gpiob_group_or #(
    parameter int W = 32,
    parameter int G = 8,
    localparam int NG = W / G
) (
    input  logic [W-1:0]  line_cause,
    output logic [NG-1:0] grp
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp[g] = |line_cause[g*G +: G];
    end
endmodule

// File: rtl/gpio_cause_bank.sv
module gpio_cause_bank #(
    parameter int LINES  = 32,
    parameter int GROUP  = 8,
    localparam int NGROUP = LINES / GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic [NGROUP-1:0] irq_group
);
    import gpiob_pkg::*;

    reg_sel_e         sel;
    logic [LINES-1:0] dir_q, out_q, pol_q, emask_q, lmask_q;
    logic [LINES-1:0] pin_sync, din, din_prev, ecause_q, line_cause;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            out_q   <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                REG_DIR:   dir_q   <= reg_wdata;
                REG_OUT:   out_q   <= reg_wdata;
                REG_POL:   pol_q   <= reg_wdata;
                REG_EMASK: emask_q <= reg_wdata;
                REG_LMASK: lmask_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    gpiob_sync #(.W(LINES), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign din = pin_sync ^ pol_q;

    gpiob_edge_cause #(.W(LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .clr_we   (reg_wr && sel == REG_ECAUSE),
        .clr_data (reg_wdata),
        .din_prev (din_prev),
        .cause    (ecause_q)
    );

    assign line_cause = (din & lmask_q) | (ecause_q & emask_q);

    gpiob_group_or #(.W(LINES), .G(GROUP)) u_grp (
        .line_cause (line_cause),
        .grp        (irq_group)
    );

    always_comb begin
        unique case (sel)
            REG_DIR:    reg_rdata = dir_q;
            REG_OUT:    reg_rdata = out_q;
            REG_POL:    reg_rdata = pol_q;
            REG_DIN:    reg_rdata = din;
            REG_ECAUSE: reg_rdata = ecause_q;
            REG_EMASK:  reg_rdata = emask_q;
            REG_LMASK:  reg_rdata = lmask_q;
            REG_NONE:   reg_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpiob_checker.sv
module gpiob_checker #(
    parameter int W  = 32,
    parameter int NG = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    reg_addr,
    input logic          reg_wr,
    input logic [W-1:0]  reg_wdata,
    input logic [W-1:0]  pin_oe,
    input logic [NG-1:0] irq_group,
    input logic [W-1:0]  din,
    input logic [W-1:0]  din_prev,
    input logic [W-1:0]  ecause,
    input logic [W-1:0]  lmask,
    input logic [W-1:0]  emask
);
    localparam logic [2:0] SEL_DIR    = 3'd0;
    localparam logic [2:0] SEL_ECAUSE = 3'd4;

    p_oe_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_DIR) |=> (pin_oe == ~$past(reg_wdata)));

    // Also covers R10: the event bit is set even under a clearing write.
    p_edge_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(din & ~din_prev)) |=>
            ((ecause & $past(din & ~din_prev)) == $past(din & ~din_prev)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == SEL_ECAUSE) |=> ((ecause & $past(ecause)) == $past(ecause)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_ECAUSE) |=>
            ((ecause & ~$past(reg_wdata) & ~$past(din & ~din_prev)) == '0));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((din & lmask) == '0) && ((ecause & emask) == '0)) |-> (irq_group == '0));
endmodule

bind gpio_cause_bank gpiob_checker #(.W(LINES), .NG(NGROUP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pin_oe    (pin_oe),
    .irq_group (irq_group),
    .din       (din),
    .din_prev  (din_prev),
    .ecause    (ecause_q),
    .lmask     (lmask_q),
    .emask     (emask_q)
);

// File: tb/sim_gpio_cause_bank.sv
`timescale 1ns/1ps
module sim_gpio_cause_bank;
    localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_POL = 3'd2, A_DIN = 3'd3,
                           A_EC = 3'd4, A_EM = 3'd5, A_LM = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [3:0]  irq_group;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_cause_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_group(irq_group)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk); pin_in = pin_in | m;
        settle();
        pin_in = pin_in & ~m;
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_DIR, v); check("R1 dir", v, 32'hffff_ffff);
        check("R1 oe", pin_oe, 32'h0);
        rd(A_OUT, v); check("R1 out", v, 32'h0);
        rd(A_POL, v); check("R1 pol", v, 32'h0);
        rd(A_EC, v);  check("R1 ecause", v, 32'h0);
        rd(A_EM, v);  check("R1 emask", v, 32'h0);
        rd(A_LM, v);  check("R1 lmask", v, 32'h0);
        check("R1 irq", {28'h0, irq_group}, 32'h0);
    endtask

    task automatic t_din();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'ha5a5_0f0f;
        settle();
        rd(A_DIN, v); check("R2 din", v, 32'ha5a5_0f0f);
        wr(A_POL, 32'hffff_0000);
        rd(A_DIN, v); check("R2 din pol", v, 32'h5a5a_0f0f);
        @(negedge clk); pin_in = 32'ha5a5_0f1f;
        @(negedge clk); rd(A_DIN, v); check("R2 one edge", v, 32'h5a5a_0f0f);
        @(negedge clk); rd(A_DIN, v); check("R2 two edges", v, 32'h5a5a_0f1f);
        @(negedge clk); pin_in = '0;
        wr(A_POL, 32'h0);
        settle();
        wr(A_EC, 32'h0);
    endtask

    task automatic t_dir();
        wr(A_OUT, 32'h1234_5678);
        wr(A_DIR, 32'hffff_0000);
        check("R3 oe", pin_oe, 32'h0000_ffff);
        check("R3 out", pin_out, 32'h1234_5678);
        wr(A_DIR, 32'hffff_ffff);
    endtask

    task automatic t_level();
        wr(A_LM, 32'h8000_0100);
        @(negedge clk); pin_in = 32'h0000_0100;
        settle();
        check("R4 level on", {28'h0, irq_group}, 32'h2);
        @(negedge clk); pin_in = 32'h0;
        settle();
        check("R4 no latch", {28'h0, irq_group}, 32'h0);
        @(negedge clk); pin_in = 32'h8000_0080;
        settle();
        check("R9 group3 only", {28'h0, irq_group}, 32'h8);
        @(negedge clk); pin_in = 32'h0;
        wr(A_LM, 32'h0);
        settle();
        wr(A_EC, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(A_EC, 32'h0);
        pulse(32'h0000_0008);
        rd(A_EC, v); check("R5 sticky", v, 32'h0000_0008);
        check("R8 masked", {28'h0, irq_group}, 32'h0);
        wr(A_EM, 32'h0000_0008);
        check("R8 unmasked", {28'h0, irq_group}, 32'h1);
        wr(A_EC, ~32'h0000_0008);
        rd(A_EC, v); check("R7 clear one", v, 32'h0);
        check("R8 irq drops", {28'h0, irq_group}, 32'h0);
        wr(A_EM, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'h0010_0000;
        settle();
        wr(A_EC, 32'h0);
        pin_in = 32'h0;
        settle();
        rd(A_EC, v); check("R6 fall pol0", v, 32'h0);
        @(negedge clk); pin_in = 32'h0010_0000;
        settle();
        wr(A_POL, 32'h0010_0000);
        wr(A_EC, 32'h0);
        @(negedge clk); pin_in = 32'h0;
        settle();
        rd(A_EC, v); check("R6 fall pol1", v, 32'h0010_0000);
        wr(A_POL, 32'h0);
        settle();
        wr(A_EC, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        pulse(32'h0000_0206);
        rd(A_EC, v); check("R7 set", v, 32'h0000_0206);
        wr(A_EC, ~32'h0000_0004);
        rd(A_EC, v); check("R7 only bit2", v, 32'h0000_0202);
        wr(A_EC, 32'hffff_ffff);
        rd(A_EC, v); check("R7 ones keep", v, 32'h0000_0202);
        wr(A_EC, 32'h0);
        rd(A_EC, v); check("R7 all clear", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        pulse(32'h0000_1000);
        @(negedge clk); pin_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        reg_addr = A_EC; reg_wdata = 32'h0; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_EC, v); check("R10 event wins", v, 32'h0000_0020);
        pin_in = 32'h0;
        settle();
        wr(A_EC, 32'h0);
    endtask

    task automatic t_ro();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'h0f00_00f0;
        settle();
        wr(A_EC, 32'h0);
        wr(A_DIN, 32'hffff_ffff);
        rd(A_DIN, v); check("R11 din ro", v, 32'h0f00_00f0);
        rd(A_POL, v); check("R11 pol kept", v, 32'h0);
        rd(A_DIR, v); check("R11 dir kept", v, 32'hffff_ffff);
        @(negedge clk); pin_in = 32'h0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_din();
        t_dir();
        t_level();
        t_edge();
        t_fall();
        t_clear();
        t_race();
        t_ro();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule